// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block produces a square-wave buzzer tone from a 32.768 kHz clock-enable tick that runs alongside the system clock. A single write strobe loads three things together: a 4-bit frequency code, a 2-bit sound mode and a start bit. The tone period is set by the code. The mode decides when the tone may sound: continuously, as one short burst, as an 8 Hz on/off pattern, or as groups of those 8 Hz bursts in the first half of every second. The block drives the tone on one pin and its exact inverse on a second pin, and it raises a busy flag while a single burst is playing.

Gating is timed by a slot timer that restarts on every write. A slot lasts `SLOT_TICKS` ticks, which is 2048 by default (62.5 ms). Sixteen slots make one second. A gating state machine has the states IDLE, CONT, SHOT, PULSE and GROUP:
- A write with start = 0 moves it to IDLE.
- A write with start = 1 moves it to the state picked by the mode.
- SHOT returns to IDLE by itself once the slot index reaches 2.

The tone divider changes its frequency code only at a half-period boundary. While the gate is closed it holds the tone low and restarts, so each opened window begins with a full low half period.

Top module: `buzzer_tone_gen`

## Requirements
- R1: While reset is asserted and right after it, tone_o is 0, tone_n_o is 1 and busy_o is 0.
- R2: A cycle with wr_en = 1 loads wr_freq, wr_mode and wr_start. A write with wr_start = 0 silences the tone and clears busy_o, whatever the mode.
- R3: For frequency code c in 1..15, each half period of the tone lasts 18 - c ticks. Code 15 gives 32768/6, about 5.461 kHz, and code 1 gives 32768/34, about 0.964 kHz. Code 0 keeps the tone silent.
- R4: tone_n_o is always the logical inverse of tone_o.
- R5: In mode 0 (continuous) the tone is allowed in every slot until the next write.
- R6: In mode 2 (intermittent 1) the tone is allowed only in even slot indices. This is an 8 Hz pattern with 50 % duty.
- R7: In mode 3 (intermittent 2) the tone is allowed only in even slot indices 0..6 of each 16-slot second, and is silent in slots 8..15.
- R8: In mode 1 (simple sound) a start write sets busy_o from the next cycle. The tone is allowed while busy. The state returns to IDLE, and busy_o falls, one cycle after the slot index reaches 2 (125 ms by default), with no further write.
- R9: When the tone is gated off, tone_o rests at 0. When gating reopens, the tone starts with a full low half period.
- R10: A new frequency code written while the tone is sounding takes effect only at the end of the current half period.
- R11: Every write restarts the slot timer at slot 0. The slot timer and the tone advance only in cycles where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 32.768 kHz clock-enable pulse |
| wr_en | input | 1 | Write strobe for the control fields |
| wr_freq | input | 4 | Frequency code; 0 = silent |
| wr_mode | input | 2 | 0 continuous, 1 simple, 2 intermittent 1, 3 intermittent 2 |
| wr_start | input | 1 | 1 starts sound, 0 stops it |
| tone_o | output | 1 | Tone, non-inverted |
| tone_n_o | output | 1 | Tone, inverted |
| busy_o | output | 1 | High while a simple-sound burst plays |

## Verification
The faults that matter here are a wrong slot index, a wrong gating state, or a stale divider code. At the ports they show up as a tone edge that lands one or more ticks early or late, a window that opens in the wrong slot, or busy_o that stays up or drops early. Each of these moves an output within one half period or one slot of the fault. The bench therefore compares all three outputs against a behavioural model on every clock, under several tick rates. Any misplaced edge is caught in the cycle it appears.

// File: rtl/buz_pkg.sv
package buz_pkg;

    typedef enum logic [1:0] {
        SND_CONT  = 2'd0,
        SND_SHOT  = 2'd1,
        SND_PULSE = 2'd2,
        SND_GROUP = 2'd3
    } snd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONT  = 3'd1,
        ST_SHOT  = 3'd2,
        ST_PULSE = 3'd3,
        ST_GROUP = 3'd4
    } gate_state_e;

    function automatic gate_state_e state_for_mode(input snd_mode_e m);
        gate_state_e s;
        unique case (m)
            SND_CONT:  s = ST_CONT;
            SND_SHOT:  s = ST_SHOT;
            SND_PULSE: s = ST_PULSE;
            default:   s = ST_GROUP;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/buz_slot_timer.sv
module buz_slot_timer #(
    parameter int SLOT_TICKS = 2048,
    parameter int SLOT_IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  clr_i,
    output logic [SLOT_IDX_W-1:0] slot_idx_o
);
    localparam int CNT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            slot_idx_o <= '0;
        end else if (clr_i) begin
            cnt_q      <= '0;
            slot_idx_o <= '0;
        end else if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q      <= '0;
                slot_idx_o <= slot_idx_o + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_SLOT_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> $stable(slot_idx_o)); // R11

endmodule

// File: rtl/buz_gate_fsm.sv
module buz_gate_fsm
    import buz_pkg::*;
#(
    parameter int SLOT_IDX_W  = 4,
    parameter int BURST_SLOTS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  start_i,
    input  snd_mode_e             mode_i,
    input  logic [SLOT_IDX_W-1:0] slot_idx_i,
    output logic                  gate_o,
    output logic                  busy_o
);
    localparam logic [SLOT_IDX_W-1:0] BURST_END = SLOT_IDX_W'(BURST_SLOTS);

    gate_state_e state_q, state_d;
    logic        even_slot, first_half;

    assign even_slot  = ~slot_idx_i[0];
    assign first_half = ~slot_idx_i[SLOT_IDX_W-1];

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            state_d = start_i ? state_for_mode(mode_i) : ST_IDLE;
        end else if (state_q == ST_SHOT && slot_idx_i == BURST_END) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:  gate_o <= 1'b0;
                ST_CONT:  gate_o <= 1'b1;
                ST_SHOT:  gate_o <= 1'b1;
                ST_PULSE: gate_o <= even_slot;
                ST_GROUP: gate_o <= even_slot & first_half;
                default:  gate_o <= 1'b0;
            endcase
        end
    end

    assign busy_o = (state_q == ST_SHOT);

    AST_BURST_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (slot_idx_i <= BURST_END)); // R8

endmodule

// File: rtl/buz_tone_div.sv
module buz_tone_div #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              gate_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tone_o
);
    localparam int HALF_BASE = (1 << CODE_W) + 2;
    localparam int HCNT_W    = $clog2(HALF_BASE);

    logic [CODE_W-1:0] cur_q;
    logic [HCNT_W-1:0] hcnt_q;
    logic [HCNT_W-1:0] last_cnt;
    logic              idle;

    assign last_cnt = HCNT_W'(HALF_BASE - 1) - HCNT_W'(cur_q);
    assign idle     = !gate_i || (cur_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            hcnt_q <= '0;
            tone_o <= 1'b0;
        end else if (idle) begin
            cur_q  <= code_i;
            hcnt_q <= '0;
            tone_o <= 1'b0;
        end else if (tick_i) begin
            if (hcnt_q == last_cnt) begin
                hcnt_q <= '0;
                cur_q  <= code_i;
                tone_o <= (code_i != '0) ? ~tone_o : 1'b0;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    AST_SILENT_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> !tone_o); // R9

    AST_CODE_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && cur_q != '0 && !tick_i) |=> ($stable(cur_q) && $stable(tone_o))); // R10

endmodule

// File: rtl/buzzer_tone_gen.sv
module buzzer_tone_gen
    import buz_pkg::*;
#(
    parameter int SLOT_TICKS  = 2048,
    parameter int SLOT_IDX_W  = 4,
    parameter int BURST_SLOTS = 2,
    parameter int CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_freq,
    input  logic [1:0]        wr_mode,
    input  logic              wr_start,
    output logic              tone_o,
    output logic              tone_n_o,
    output logic              busy_o
);
    logic [CODE_W-1:0]     freq_q;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic                  gate_w;
    logic                  tone_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     freq_q <= '0;
        else if (wr_en) freq_q <= wr_freq;
    end

    buz_slot_timer #(.SLOT_TICKS(SLOT_TICKS), .SLOT_IDX_W(SLOT_IDX_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .clr_i      (wr_en),
        .slot_idx_o (slot_idx)
    );

    buz_gate_fsm #(.SLOT_IDX_W(SLOT_IDX_W), .BURST_SLOTS(BURST_SLOTS)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_en),
        .start_i    (wr_start),
        .mode_i     (snd_mode_e'(wr_mode)),
        .slot_idx_i (slot_idx),
        .gate_o     (gate_w),
        .busy_o     (busy_o)
    );

    buz_tone_div #(.CODE_W(CODE_W)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .gate_i (gate_w),
        .code_i (freq_q),
        .tone_o (tone_w)
    );

    assign tone_o   = tone_w;
    assign tone_n_o = ~tone_w;

    AST_TONE_RISES_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_o) |-> $past(gate_w)); // R9

endmodule

// File: tb/buzzer_tone_gen_tb.sv
module buzzer_tone_gen_tb_top;
    localparam int CLK_P  = 10;
    localparam int SLOT_T = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_freq = 4'd0;
    logic [1:0] wr_mode = 2'd0;
    logic       wr_start = 1'b0;
    logic       tone_o, tone_n_o, busy_o;

    int checks = 0;
    int failures = 0;
    int tick_period = 1;
    int tcnt = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural model: 0 idle, 1 cont, 2 shot, 3 pulse, 4 group
    int m_state = 0, m_idx = 0, m_cnt = 0, m_code = 0, m_h = 0, m_freq = 0;
    bit m_gate = 0, m_tog = 0;

    always #(CLK_P/2) clk = ~clk;

    buzzer_tone_gen #(.SLOT_TICKS(SLOT_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_freq(wr_freq),
        .wr_mode(wr_mode), .wr_start(wr_start), .tone_o(tone_o), .tone_n_o(tone_n_o),
        .busy_o(busy_o)
    );

    always @(negedge clk) begin
        tick <= (tcnt % tick_period) == 0;
        tcnt <= tcnt + 1;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_cnt = 0; m_code = 0; m_h = 0;
            m_freq = 0; m_gate = 0; m_tog = 0;
        end else begin
            bit g_n;
            int st_n;
            case (m_state)
                1, 2:    g_n = 1;
                3:       g_n = (m_idx % 2) == 0;
                4:       g_n = (m_idx < 8) && (m_idx % 2) == 0;
                default: g_n = 0;
            endcase
            if (!m_gate || m_code == 0) begin
                m_code = m_freq; m_h = 0; m_tog = 0;
            end else if (tick) begin
                if (m_h == 18 - m_code - 1) begin
                    m_h = 0;
                    m_tog = (m_freq != 0) ? !m_tog : 1'b0;
                    m_code = m_freq;
                end else begin
                    m_h++;
                end
            end
            st_n = m_state;
            if (wr_en) st_n = wr_start ? int'(wr_mode == 0 ? 1 : wr_mode == 1 ? 2 : wr_mode == 2 ? 3 : 4) : 0;
            else if (m_state == 2 && m_idx == 2) st_n = 0;
            if (wr_en) begin
                m_idx = 0; m_cnt = 0;
            end else if (tick) begin
                if (m_cnt == SLOT_T - 1) begin m_cnt = 0; m_idx = (m_idx + 1) % 16; end
                else m_cnt++;
            end
            if (wr_en) m_freq = wr_freq;
            m_state = st_n;
            m_gate = g_n;
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_bit(cur_req, "tone_o", tone_o, m_tog);
            check_bit(cur_req, "busy_o", busy_o, m_state == 2);
            check_bit("R4", "tone_n_o", tone_n_o, ~tone_o);
        end
    end

    task automatic do_write(int code, int mode, bit start);
        @(negedge clk);
        wr_en = 1'b1; wr_freq = 4'(code); wr_mode = 2'(mode); wr_start = start;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        run(3);
        check_bit("R1", "tone_o in reset", tone_o, 1'b0);
        check_bit("R1", "tone_n_o in reset", tone_n_o, 1'b1);
        check_bit("R1", "busy_o in reset", busy_o, 1'b0);
        rst_n = 1'b1;
        run(2);
        check_bit("R1", "tone_o after reset", tone_o, 1'b0);
        check_bit("R1", "busy_o after reset", busy_o, 1'b0);

        cur_req = "R5";  do_write(15, 0, 1'b1); run(300);   // R3 highest code, continuous
        cur_req = "R10"; do_write(1, 0, 1'b1);  run(200);   // change mid-period
        cur_req = "R3";  do_write(7, 0, 1'b1);  run(200);
        cur_req = "R3";  do_write(0, 0, 1'b1);  run(100);   // code 0 silent
        check_bit("R3", "code 0 silent", tone_o, 1'b0);
        cur_req = "R6";  tick_period = 2; do_write(10, 2, 1'b1); run(700);
        cur_req = "R7";  tick_period = 1; do_write(12, 3, 1'b1); run(600);
        cur_req = "R11"; tick_period = 3; do_write(14, 3, 1'b1); run(900);
        cur_req = "R8";  tick_period = 1; do_write(5, 1, 1'b1); run(2);
        check_bit("R8", "busy after start", busy_o, 1'b1);
        run(80);
        check_bit("R8", "busy cleared by itself", busy_o, 1'b0);
        do_write(9, 1, 1'b1); run(20);
        cur_req = "R8";  do_write(9, 1, 1'b1); run(60);     // retrigger mid-burst
        cur_req = "R2";  do_write(9, 0, 1'b1); run(40);
        do_write(9, 1, 1'b0); run(50);                      // stop write
        check_bit("R2", "stop write silences", tone_o, 1'b0);
        check_bit("R2", "stop write clears busy", busy_o, 1'b0);
        cur_req = "R9";  do_write(13, 2, 1'b1); run(150);
        report();
    end
endmodule